// File: doc/BRIEF.md
# Shared Forward/Inverse Column Mixer

This block mixes one four-byte column of a 128-bit block cipher state. A single mode input chooses the result. The forward result multiplies the column, read as a polynomial over GF(2^8), by {03}x^3 + {01}x^2 + {01}x + {02} modulo x^4 + 1. The inverse result uses {0B}x^3 + {0D}x^2 + {09}x + {0E} instead. Field products reduce by x^8 + x^4 + x^3 + x + 1.

The inverse result has no multipliers of its own for 0E, 0B, 0D or 09. The forward bytes are always computed. The inverse bytes come from them through one extra stage, which adds a times-four correction term to each byte. Each correction term is shared by two bytes. A round controller places the block between the substitution/shift stage and the key addition. The output can be a plain combinational path, or it can go through one pipeline register. A parameter chooses which.

Top module: `mixcol_unit`

## Requirements
- R1: While `rst` is high, the registered output `col_out` is 0x00000000 one clock after each rising edge.
- R2: In forward mode (`inv_mode` = 0), column 0xdb135345 gives 0x8e4da1bc, and column 0xd4bf5d30 gives 0x046681e5.
- R3: In inverse mode (`inv_mode` = 1), column 0x8e4da1bc gives 0xdb135345, and column 0x046681e5 gives 0xd4bf5d30.
- R4: A column whose four bytes are all equal is returned unchanged in both modes. For example, 0x01010101 gives 0x01010101 and 0xc6c6c6c6 gives 0xc6c6c6c6.
- R5: For any column, the forward result equals multiplication by the forward polynomial. The XOR of the four output bytes equals the XOR of the four input bytes.
- R6: Applying the inverse mode to any forward result returns the original column.
- R7: The first byte of the column (the constant-term coefficient) sits in bits [31:24], and the last byte sits in bits [7:0]. For example, forward 0xd4d4d4d5 gives 0xd5d5d7d6.
- R8: With the output register enabled, `col_out` shows the result for the `col_in` and `inv_mode` sampled at the previous rising edge. The mode may change on every cycle.
- R9: For any column, the inverse result equals multiplication by the inverse polynomial. The XOR of the four output bytes equals the XOR of the four input bytes.
- R10: The all-zero column gives zero in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset that clears the output register |
| inv_mode | input | 1 | 0 selects the forward mix, 1 selects the inverse mix |
| col_in | input | 32 | Input column, first byte in [31:24] |
| col_out | output | 32 | Mixed column, first byte in [31:24] |

## Verification
The block holds no state apart from the one output register, so an internal error shows at the port on the very next edge. A wrong product term or a wrong reduction constant corrupts specific bytes of fixed vectors and breaks the round trip for most random columns. A wrong byte rotation or a wrong sharing of a correction term swaps or spoils bytes only when the column bytes differ, so flat columns alone cannot reveal it. A mode that is sampled one cycle late shows up when the mode alternates on every cycle.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int COL_W  = BYTE_W * LANES;

    typedef logic [BYTE_W-1:0] gf_byte_t;
    typedef gf_byte_t lane_vec_t [LANES];

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } mix_dir_e;

    localparam gf_byte_t REDUCE_MASK = 8'h1B;

    // multiply by x in GF(2^8)
    function automatic gf_byte_t gf_x2(input gf_byte_t v);
        return {v[BYTE_W-2:0], 1'b0} ^ (v[BYTE_W-1] ? REDUCE_MASK : '0);
    endfunction

    // multiply by x^2 in GF(2^8)
    function automatic gf_byte_t gf_x4(input gf_byte_t v);
        return gf_x2(gf_x2(v));
    endfunction

    // lane 0 is the most significant byte of the word
    function automatic lane_vec_t unpack_col(input logic [COL_W-1:0] w);
        lane_vec_t r;
        for (int i = 0; i < LANES; i++)
            r[i] = w[COL_W-1-BYTE_W*i -: BYTE_W];
        return r;
    endfunction

    function automatic logic [COL_W-1:0] pack_col(input lane_vec_t l);
        logic [COL_W-1:0] w;
        for (int i = 0; i < LANES; i++)
            w[COL_W-1-BYTE_W*i -: BYTE_W] = l[i];
        return w;
    endfunction

    function automatic gf_byte_t lane_xor(input lane_vec_t l);
        gf_byte_t acc = '0;
        for (int i = 0; i < LANES; i++)
            acc ^= l[i];
        return acc;
    endfunction

endpackage

// File: rtl/mixcol_fwd.sv
module mixcol_fwd
    import mixcol_pkg::*;
(
    input  lane_vec_t a_in,
    output lane_vec_t f_out
);
    gf_byte_t total;

    assign total = lane_xor(a_in);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int NXT = (i + 1) % LANES;
        assign f_out[i] = total ^ gf_x2(a_in[i] ^ a_in[NXT]) ^ a_in[i];
    end

    // coefficient sum 02^03^01^01 = 01 keeps the byte-wise XOR
    always_comb begin
        assert_fwd_sum_R5: assert (lane_xor(f_out) == lane_xor(a_in))
            else $error("forward byte sum mismatch");
    end

endmodule

// File: rtl/mixcol_inv_fix.sv
module mixcol_inv_fix
    import mixcol_pkg::*;
(
    input  lane_vec_t f_in,
    output lane_vec_t i_out
);
    localparam int HALF = LANES / 2;

    gf_byte_t corr [HALF];

    for (genvar p = 0; p < HALF; p++) begin : g_corr
        assign corr[p] = gf_x4(f_in[p] ^ f_in[p + HALF]);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign i_out[i] = f_in[i] ^ corr[i % HALF];
    end

    // each correction term lands on two bytes and cancels in the sum
    always_comb begin
        assert_inv_sum_R9: assert (lane_xor(i_out) == lane_xor(f_in))
            else $error("inverse byte sum mismatch");
        assert_inv_zero_R10: assert ((f_in[0] | f_in[1] | f_in[2] | f_in[3]) != '0
                                     || (i_out[0] | i_out[1] | i_out[2] | i_out[3]) == '0)
            else $error("zero column not preserved");
    end

endmodule

// File: rtl/mixcol_unit.sv
module mixcol_unit
    import mixcol_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inv_mode,
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);
    mix_dir_e         dir;
    lane_vec_t        lanes_in;
    lane_vec_t        lanes_fwd;
    lane_vec_t        lanes_inv;
    logic [COL_W-1:0] result_c;

    assign dir      = mix_dir_e'(inv_mode);
    assign lanes_in = unpack_col(col_in);

    mixcol_fwd u_fwd (
        .a_in  (lanes_in),
        .f_out (lanes_fwd)
    );

    mixcol_inv_fix u_inv (
        .f_in  (lanes_fwd),
        .i_out (lanes_inv)
    );

    assign result_c = (dir == DIR_INV) ? pack_col(lanes_inv) : pack_col(lanes_fwd);

    if (REG_OUT) begin : g_reg
        logic [COL_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (rst) out_q <= '0;
            else     out_q <= result_c;
        end

        assign col_out = out_q;

        // flat columns are fixed points in both directions
        assert_flat_fixed_R4: assert property (@(posedge clk) disable iff (rst)
            (col_in[31:24] == col_in[23:16] && col_in[23:16] == col_in[15:8]
             && col_in[15:8] == col_in[7:0])
            |=> col_out == $past(col_in))
            else $error("flat column altered");

        assert_zero_col_R10: assert property (@(posedge clk) disable iff (rst)
            (col_in == '0) |=> (col_out == '0))
            else $error("zero column altered");
    end else begin : g_comb
        assign col_out = result_c;
    end

endmodule

// File: tb/mixcol_unit_tb.sv
`timescale 1ns/1ps
module mixcol_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        inv_mode;
    logic [31:0] col_in;
    logic [31:0] col_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mixcol_unit #(.REG_OUT(1'b1)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .inv_mode (inv_mode),
        .col_in   (col_in),
        .col_out  (col_out)
    );

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] aa = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p ^= aa;
            aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
        end
        return p;
    endfunction

    // circulant matrix product; row r uses coef[(c - r) mod 4]
    function automatic logic [31:0] ref_mix(input logic [31:0] w, input bit inv);
        logic [7:0] coef [4];
        logic [7:0] a [4];
        logic [31:0] r = '0;
        if (inv) begin coef[0]=8'h0e; coef[1]=8'h0b; coef[2]=8'h0d; coef[3]=8'h09; end
        else     begin coef[0]=8'h02; coef[1]=8'h03; coef[2]=8'h01; coef[3]=8'h01; end
        for (int i = 0; i < 4; i++) a[i] = w[31-8*i -: 8];
        for (int row = 0; row < 4; row++) begin
            logic [7:0] acc = 8'h00;
            for (int c = 0; c < 4; c++) acc ^= gmul(coef[(c - row + 4) % 4], a[c]);
            r[31-8*row -: 8] = acc;
        end
        return r;
    endfunction

    task automatic check(input logic [31:0] exp, input string tag);
        checks++;
        if (col_out !== exp) begin
            errors++;
            $display("FAIL %s: col_out=%08h expected=%08h", tag, col_out, exp);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge (one register)
    task automatic step(input bit mode, input logic [31:0] data,
                        input logic [31:0] exp, input string tag);
        inv_mode = mode;
        col_in   = data;
        @(negedge clk);
        check(exp, tag);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; inv_mode = 1'b1; col_in = 32'hdeadbeef;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(32'h0, "R1 reset");
        end
        rst = 1'b0;

        step(1'b0, 32'hdb135345, 32'h8e4da1bc, "R2 vector a");
        step(1'b0, 32'hd4bf5d30, 32'h046681e5, "R2 vector b");
        step(1'b1, 32'h8e4da1bc, 32'hdb135345, "R3 vector a");
        step(1'b1, 32'h046681e5, 32'hd4bf5d30, "R3 vector b");
        step(1'b0, 32'h01010101, 32'h01010101, "R4 flat fwd");
        step(1'b1, 32'hc6c6c6c6, 32'hc6c6c6c6, "R4 flat inv");
        step(1'b0, 32'hd4d4d4d5, 32'hd5d5d7d6, "R7 byte order");
        step(1'b0, 32'h00000000, 32'h00000000, "R10 zero fwd");
        step(1'b1, 32'h00000000, 32'h00000000, "R10 zero inv");

        // mid-run reset clears the register again
        rst = 1'b1;
        step(1'b0, 32'h12345678, 32'h0, "R1 reset midrun");
        rst = 1'b0;

        for (int n = 0; n < 200; n++) begin
            logic [31:0] x = $urandom;
            logic [31:0] f = ref_mix(x, 1'b0);
            step(1'b0, x, f, "R5 forward random");
            step(1'b1, f, x, "R6 round trip");
            step(1'b1, x, ref_mix(x, 1'b1), "R9 inverse random");
        end

        // mode toggled each cycle on a fixed column
        for (int n = 0; n < 16; n++) begin
            logic [31:0] x = 32'h0f1e2d3c + 32'(n * 32'h01010101);
            step(n[0], x, ref_mix(x, n[0]), "R8 mode toggle");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule